// File: doc/BRIEF.md
# Per-Instruction Stride Predictor for Data Address Traces

This block shrinks a stream of data memory accesses before it leaves the chip. Each access arrives as an instruction address and the data address that instruction touched. A small input queue takes the pairs in. A direct-mapped table with no tags holds one entry per slot, chosen by a few bits of the instruction address. Each entry keeps the last data address seen and the last stride seen.

For every access the block takes the new address minus the stored last address. It compares that difference with the stored stride. A match produces a single 1 bit. A mismatch produces a 0 bit, sends the full data address out on a separate miss channel, and stores the new stride.

The hit/miss bits are gathered into bytes before they leave. A downstream stage can then run-length code them or place them on a trace port. Since most loop accesses advance by a fixed step, a long run of accesses usually costs one bit each.

Top module: `stride_trace_compressor`

## Requirements
- R1: The table slot is selected by instruction address bits [11:2] (10 index bits, 1024 slots); entries carry no tag, so two instructions whose bits [11:2] agree share one slot.
- R2: The current stride is the data address minus the slot's stored last address, modulo 2^32; when it equals the stored stride sign-extended from 16 bits, the access is a hit and emits a 1 bit.
- R3: Any access that is not a hit emits a 0 bit and presents its full 32-bit data address on `miss_addr` with `miss_valid` high for one cycle; hits produce no miss output.
- R4: On a miss the stored stride becomes the low 16 bits of the current stride; on a hit the stored stride is unchanged.
- R5: The stored last address is overwritten with the incoming data address on every access, hit or miss.
- R6: A current stride outside the signed 16-bit range [-32768, 32767] is always a miss, even when its low 16 bits equal the stored stride.
- R7: After reset every slot holds last address 0 and stride 0, so the first access through a slot hits only when its data address is 0.
- R8: Hit/miss bits are packed eight to a byte in arrival order, the earliest at bit 0; `dt_valid` pulses for one cycle with each completed byte.
- R9: The input queue holds 8 accesses; `in_ready` is low only while the queue is full or the table is being cleared, and no accepted access is lost or reordered.
- R10: From reset until the table clear finishes (1024 cycles), `in_ready`, `dt_valid` and `miss_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Access offered on `in_pc`/`in_addr` |
| in_ready | output | 1 | Queue accepts an access this cycle |
| in_pc | input | 32 | Instruction address of the access |
| in_addr | input | 32 | Data address of the access |
| dt_valid | output | 1 | Packed hit/miss byte valid (one cycle) |
| dt_byte | output | 8 | Eight hit/miss bits, earliest in bit 0 |
| miss_valid | output | 1 | Miss address valid (one cycle) |
| miss_addr | output | 32 | Full data address of a mispredicted access |

## Verification
The bench first checks the reset state. A slot that was never touched must hit at address 0, and it must miss anywhere else. If the clear after reset is skipped, slots come up with stale contents and those first outcomes turn random.

A stride equal to 65536 is aimed at a slot whose stored stride is 0. A design that compares only 16 bits would report false hits there. Negative strides are also run. A design that zero-extends the stored stride would miss on every backward walk.

Two instruction addresses that alias to one slot are interleaved, and they must disturb each other's history. A burst longer than the queue forces `in_ready` low. Dropped or reordered accesses would then show up as wrong miss addresses or a shifted bit order within the packed bytes.

// File: rtl/strc_pkg.sv
package strc_pkg;
  localparam int STRC_ADDR_W   = 32;
  localparam int STRC_STRIDE_W = 16;

  typedef struct packed {
    logic [STRC_ADDR_W-1:0]   last_addr;
    logic [STRC_STRIDE_W-1:0] stride;
  } strc_entry_t;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_FETCH = 2'd1,
    ST_EVAL  = 2'd2
  } strc_state_t;
endpackage

// File: rtl/strc_fifo.sv
module strc_fifo #(
  parameter int DATA_W = 42,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign head_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("pop from empty queue"); // R9
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    (push && full) |-> pop) else $error("push into full queue"); // R9
endmodule

// File: rtl/strc_table.sv
module strc_table #(
  parameter int IDX_W = 10,
  parameter int ENT_W = 48
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/strc_packer.sv
module strc_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_val,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shadow;
  logic [CNT_W-1:0]  fill;
  logic [BYTE_W-1:0] merged;

  always_comb begin
    merged       = shadow;
    merged[fill] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow     <= '0;
      fill       <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (bit_valid) begin
        if (fill == CNT_W'(BYTE_W - 1)) begin
          byte_valid <= 1'b1;
          byte_data  <= merged;
          shadow     <= '0;
          fill       <= '0;
        end else begin
          shadow <= merged;
          fill   <= fill + 1'b1;
        end
      end
    end
  end

  AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid) else $error("back-to-back bytes"); // R8
endmodule

// File: rtl/stride_trace_compressor.sv
module stride_trace_compressor
  import strc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = STRC_ADDR_W,
  parameter int STRIDE_W   = STRC_STRIDE_W,
  parameter int IDX_W      = 10,
  parameter int PC_LSB     = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              dt_valid,
  output logic [BYTE_W-1:0] dt_byte,
  output logic              miss_valid,
  output logic [ADDR_W-1:0] miss_addr
);
  localparam int ENT_W  = ADDR_W + STRIDE_W;
  localparam int Q_W    = IDX_W + ADDR_W;
  localparam int EXT_W  = ADDR_W - STRIDE_W + 1;

  strc_state_t       state;
  logic [IDX_W-1:0]  clr_idx;
  logic              q_full, q_empty, q_pop;
  logic [Q_W-1:0]    q_head;
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] cur_addr;
  logic [ENT_W-1:0]  rd_raw, wr_raw;
  strc_entry_t       rd_ent, wr_ent;
  logic              tbl_we;
  logic [IDX_W-1:0]  tbl_widx;
  logic [ADDR_W-1:0] delta, stored_ext;
  logic              fits, hit, eval_now;

  assign in_ready = (state != ST_CLEAR) && !q_full;
  assign q_pop    = (state == ST_FETCH) && !q_empty;
  assign eval_now = (state == ST_EVAL);

  strc_fifo #(.DATA_W(Q_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(in_valid && in_ready),
    .push_data({in_pc[PC_LSB +: IDX_W], in_addr}),
    .pop(q_pop), .head_data(q_head),
    .full(q_full), .empty(q_empty)
  );

  assign rd_ent     = strc_entry_t'(rd_raw);
  assign delta      = cur_addr - rd_ent.last_addr;
  assign fits       = (delta[ADDR_W-1 -: EXT_W] == '0) || (delta[ADDR_W-1 -: EXT_W] == '1);
  assign stored_ext = {{(ADDR_W-STRIDE_W){rd_ent.stride[STRIDE_W-1]}}, rd_ent.stride};
  assign hit        = fits && (delta == stored_ext);

  always_comb begin
    if (state == ST_CLEAR) begin
      tbl_we   = 1'b1;
      tbl_widx = clr_idx;
      wr_ent   = '0;
    end else begin
      tbl_we           = eval_now;
      tbl_widx         = cur_idx;
      wr_ent.last_addr = cur_addr;
      wr_ent.stride    = hit ? rd_ent.stride : delta[STRIDE_W-1:0];
    end
  end
  assign wr_raw = wr_ent;

  strc_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_table (
    .clk(clk),
    .rd_en(q_pop), .rd_idx(q_head[ADDR_W +: IDX_W]), .rd_data(rd_raw),
    .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_data(wr_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLEAR;
      clr_idx    <= '0;
      cur_idx    <= '0;
      cur_addr   <= '0;
      miss_valid <= 1'b0;
      miss_addr  <= '0;
    end else begin
      miss_valid <= 1'b0;
      case (state)
        ST_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == '1) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (q_pop) begin
            cur_idx  <= q_head[ADDR_W +: IDX_W];
            cur_addr <= q_head[ADDR_W-1:0];
            state    <= ST_EVAL;
          end
        end
        default: begin
          miss_valid <= !hit;
          miss_addr  <= cur_addr;
          state      <= ST_FETCH;
        end
      endcase
    end
  end

  strc_packer #(.BYTE_W(BYTE_W)) u_packer (
    .clk(clk), .rst(rst),
    .bit_valid(eval_now), .bit_val(hit),
    .byte_valid(dt_valid), .byte_data(dt_byte)
  );

  AST_MISS_FOLLOWS_EVAL: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> $past(eval_now)) else $error("miss without access"); // R3
  AST_QUIET_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLEAR) |-> (!in_ready && !miss_valid && !dt_valid)) else $error("activity during clear"); // R10
  AST_LAST_ADDR_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    eval_now |-> (tbl_we && wr_ent.last_addr == cur_addr)) else $error("last address not refreshed"); // R5
  AST_HIT_KEEPS_STRIDE: assert property (@(posedge clk) disable iff (rst)
    (eval_now && hit) |-> (wr_ent.stride == rd_ent.stride)) else $error("stride changed on hit"); // R4
  AST_WIDE_STRIDE_MISSES: assert property (@(posedge clk) disable iff (rst)
    (eval_now && !fits) |=> miss_valid) else $error("out-of-range stride hit"); // R6
endmodule

// File: tb/stride_trace_compressor_bench.sv
module stride_trace_compressor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [31:0] in_addr = '0;
  logic        dt_valid;
  logic [7:0]  dt_byte;
  logic        miss_valid;
  logic [31:0] miss_addr;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_last   [1024];
  logic [15:0] m_stride [1024];
  logic        exp_bits [$];
  logic [31:0] exp_miss [$];
  logic [7:0]  rx_bytes [$];
  logic [31:0] rx_miss  [$];

  always #2 clk = ~clk;

  stride_trace_compressor u_stride_trace_compressor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_addr(in_addr), .dt_valid(dt_valid), .dt_byte(dt_byte),
    .miss_valid(miss_valid), .miss_addr(miss_addr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (dt_valid)   rx_bytes.push_back(dt_byte);
      if (miss_valid) rx_miss.push_back(miss_addr);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected outcome from R1, R2, R4, R5, R6
  task automatic model(input logic [31:0] pc, input logic [31:0] addr);
    int idx;
    logic signed [31:0] d;
    bit h;
    idx = int'(pc[11:2]);
    d = addr - m_last[idx];
    h = (d >= -32768) && (d <= 32767) && (d[15:0] == m_stride[idx]);
    exp_bits.push_back(h);
    if (!h) begin
      exp_miss.push_back(addr);
      m_stride[idx] = d[15:0];
    end
    m_last[idx] = addr;
  endtask

  task automatic send(input logic [31:0] pc, input logic [31:0] addr, output bit stalled);
    bit acc;
    stalled = 0;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pc = pc;
      in_addr = addr;
      acc = in_ready;
      if (!acc) stalled = 1;
      @(posedge clk);
    end
    model(pc, addr);
  endtask

  task automatic idle_input();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain_and_compare(input string req);
    logic [7:0] eb;
    logic [31:0] em;
    idle_input();
    repeat (40) @(negedge clk);
    while (rx_miss.size() > 0) begin
      em = (exp_miss.size() > 0) ? exp_miss.pop_front() : 32'hdead_beef;
      check(rx_miss[0] == em, {req, " miss address"}, rx_miss[0], em);
      void'(rx_miss.pop_front());
    end
    check(exp_miss.size() == 0, {req, " missing miss outputs"}, 32'(exp_miss.size()), 0);
    exp_miss.delete();
    while (rx_bytes.size() > 0) begin
      eb = '0;
      for (int i = 0; i < 8; i++) eb[i] = (exp_bits.size() > 0) ? exp_bits.pop_front() : 1'b0;
      check(rx_bytes[0] == eb, {req, " R8 packed byte"}, {24'h0, rx_bytes[0]}, {24'h0, eb});
      void'(rx_bytes.pop_front());
    end
    check(exp_bits.size() < 8, {req, " R8 byte not emitted"}, 32'(exp_bits.size()), 0);
  endtask

  task automatic t_reset();
    bit any_out;
    bit early_ready;
    any_out = 0;
    early_ready = 0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (in_ready) early_ready = 1;
      if (dt_valid || miss_valid) any_out = 1;
    end
    check(!early_ready, "R10 in_ready during clear", 32'(early_ready), 0);
    check(!any_out, "R10 outputs during clear", 32'(any_out), 0);
    while (!in_ready) @(negedge clk);
    check(in_ready, "R10 ready after clear", 32'(in_ready), 1);
  endtask

  task automatic t_first_touch();
    bit s;
    send(32'h0000_0100, 32'h0000_0000, s); // R7 hit
    send(32'h0000_0104, 32'h0000_1000, s); // R7 miss
    send(32'h0000_0108, 32'h0000_0000, s);
    send(32'h0000_010c, 32'h0000_0010, s);
    drain_and_compare("R7 first touch");
  endtask

  task automatic t_stride_walk();
    bit s;
    for (int i = 0; i < 6; i++) send(32'h0000_0200, 32'h0000_2000 + 32'(4 * i), s); // R2 R4 R5
    drain_and_compare("R2 R4 R5 stride walk");
  endtask

  task automatic t_negative();
    bit s;
    for (int i = 0; i < 5; i++) send(32'h0000_0300, 32'h0000_5000 - 32'(16 * i), s); // R2 sign extension
    drain_and_compare("R2 negative stride");
  endtask

  task automatic t_alias();
    bit s;
    for (int i = 0; i < 4; i++) begin
      send(32'h0000_0400, 32'h0000_8000 + 32'(8 * i), s); // R1 slot 0x100
      send(32'h0000_1400, 32'h0009_0000 + 32'(8 * i), s); // R1 same slot, no tag
    end
    drain_and_compare("R1 aliasing");
  endtask

  task automatic t_wide_stride();
    bit s;
    send(32'h0000_0500, 32'h0000_0000, s);
    send(32'h0000_0500, 32'h0001_0000, s); // R6 low bits 0 equal stored 0
    send(32'h0000_0500, 32'h0002_0000, s); // R6 again
    send(32'h0000_0500, 32'h0002_7fff, s);
    send(32'h0000_0500, 32'h0002_fffe, s); // R2 max positive stride hits
    drain_and_compare("R6 wide stride");
  endtask

  task automatic t_burst();
    bit s;
    bit saw_stall;
    saw_stall = 0;
    for (int i = 0; i < 32; i++) begin
      send(32'h0000_0600 + 32'(4 * (i % 3)), 32'h0010_0000 + 32'(32 * i), s); // R9
      if (s) saw_stall = 1;
    end
    check(saw_stall, "R9 queue full backpressure", 32'(saw_stall), 1);
    drain_and_compare("R9 burst");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      m_last[i] = '0;
      m_stride[i] = '0;
    end
    t_reset();
    check(!dt_valid && !miss_valid, "R10 idle after clear", {30'h0, dt_valid, miss_valid}, 0);
    t_first_touch();
    t_stride_walk();
    t_negative();
    t_alias();
    t_wide_stride();
    t_burst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule